// File: doc/BRIEF.md
# ASCII Serial Command Parser

This block sits behind a UART receiver and decodes line-oriented ASCII commands that configure a frequency-disciplining controller. Bytes arrive on a valid/ready stream. The block checks each line character by character. Lines that are complete and well-formed either update a small set of configuration registers or read one of them back. A reply is then streamed byte by byte to a UART transmitter.

Every line starts with the text `?DEV:`. Next come a two-digit decimal command ID and a direction character: `:` marks a write and `?` marks a read. A write then carries eight uppercase hex digits. Every line ends with CR (0x0D) and LF (0x0A). Each write is range-checked for its own register, and a rejected write is dropped without any reply. The stored values drive output ports, and the clear command drives a one-cycle strobe.

Top module: `ascii_cmd_parser`

## Requirements
- R1: An accepted write replies with the nine bytes `?DEV:OK` CR LF. Registers take the new value on the clock edge that accepts the LF.
- R2: A read replies with `?DEV:`, the two ID digits, `:`, eight uppercase hex digits (most significant first), CR and LF. ID 03 returns `status_i` as sampled on the LF edge.
- R3: IDs 13 and 14 both write the signed 32-bit frequency offset. A write is accepted only if the value lies in 0xFFA07413..0x005F8BED inclusive. Any other value leaves the offset unchanged and produces no reply. A read of 13 or 14 returns the offset.
- R4: ID 81 accepts only 0 or 1 as the tracking enable. ID 82 accepts only averaging codes 0..6. ID 19 accepts only status-bit indexes 0x00..0x1F. Any out-of-range write changes nothing and produces no reply.
- R5: IDs 83, 84 and 85 set the 16-bit integral, proportional and differential coefficients. A write is accepted only when the upper four hex digits are zero. Reads return the coefficient zero-extended.
- R6: A write to ID 86, with any data, pulses `corr_clear_o` high for exactly one cycle and replies OK.
- R7: ID 88 sets the output-pin mode. Only values 1..6 are accepted.
- R8: Any unexpected character aborts the line silently; this includes lowercase hex and non-decimal ID digits. If that character is `?`, it starts a new line.
- R9: An unknown ID produces no reply and changes no register. The unknown IDs are every ID not listed above, plus a write to 03 and a read of 86.
- R10: `rx_ready_o` is low while a reply is pending. A reply byte is held stable until `tx_ready_i` accepts it.
- R11: After reset the registers read: offset 0, tracking on, averaging 0, Ki 2, Kp 200, Kd 0, pin mode 1, selected bit 16. No reply is pending and `rx_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received character |
| rx_valid_i | input | 1 | Received character valid |
| rx_ready_o | output | 1 | Parser can take a character |
| tx_data_o | output | 8 | Reply character |
| tx_valid_o | output | 1 | Reply character valid |
| tx_ready_i | input | 1 | Transmitter takes the reply character |
| status_i | input | 32 | Live status word returned by ID 03 |
| freq_offset_o | output | 32 | Signed frequency offset word |
| track_en_o | output | 1 | Reference tracking enable |
| avg_code_o | output | 3 | Averaging rate code |
| pid_ki_o | output | 16 | Integral coefficient |
| pid_kp_o | output | 16 | Proportional coefficient |
| pid_kd_o | output | 16 | Differential coefficient |
| corr_clear_o | output | 1 | One-cycle clear of the correction word |
| pin_mode_o | output | 3 | Output-pin mode |
| status_sel_o | output | 5 | Selected status bit index |

## Verification
If the frame state machine is stuck or desynchronised, the next well-formed line gets no reply. The harm lasts only until the following `?`, because that character always restarts the frame. A wrong register value appears on its output port in the cycle after the LF edge. It also appears in the hex digits of a read reply about twenty cycles later. A fault in the reply sequencer shows up as wrong byte counts, bytes out of order, or bytes dropped under backpressure. It also shows up as `rx_ready_o` rising before the final LF of the reply has left.

// File: rtl/acp_pkg.sv
package acp_pkg;

  typedef enum logic [3:0] {
    PS_IDLE, PS_D, PS_E, PS_V, PS_COL, PS_ID0, PS_ID1, PS_DIR, PS_DATA, PS_CR, PS_LF
  } pstate_e;

  localparam logic [7:0] CH_Q   = 8'h3F;
  localparam logic [7:0] CH_D   = 8'h44;
  localparam logic [7:0] CH_E   = 8'h45;
  localparam logic [7:0] CH_V   = 8'h56;
  localparam logic [7:0] CH_COL = 8'h3A;
  localparam logic [7:0] CH_CR  = 8'h0D;
  localparam logic [7:0] CH_LF  = 8'h0A;
  localparam logic [7:0] CH_O   = 8'h4F;
  localparam logic [7:0] CH_K   = 8'h4B;
  localparam logic [7:0] CH_0   = 8'h30;
  localparam logic [7:0] CH_A   = 8'h41;

  localparam logic [7:0] ID_STATUS = 8'h03;
  localparam logic [7:0] ID_OFFS_A = 8'h13;
  localparam logic [7:0] ID_OFFS_B = 8'h14;
  localparam logic [7:0] ID_BITSEL = 8'h19;
  localparam logic [7:0] ID_TRACK  = 8'h81;
  localparam logic [7:0] ID_AVG    = 8'h82;
  localparam logic [7:0] ID_KI     = 8'h83;
  localparam logic [7:0] ID_KP     = 8'h84;
  localparam logic [7:0] ID_KD     = 8'h85;
  localparam logic [7:0] ID_CLEAR  = 8'h86;
  localparam logic [7:0] ID_PMODE  = 8'h88;

  function automatic logic is_dec(input logic [7:0] c);
    return (c >= 8'h30) && (c <= 8'h39);
  endfunction

  function automatic logic is_hex(input logic [7:0] c);
    return is_dec(c) || ((c >= 8'h41) && (c <= 8'h46));
  endfunction

  function automatic logic [3:0] hex_val(input logic [7:0] c);
    logic [7:0] v;
    v = is_dec(c) ? (c - CH_0) : (c - CH_A + 8'd10);
    return v[3:0];
  endfunction

  function automatic logic [7:0] nib_char(input logic [3:0] n);
    return (n < 4'd10) ? (CH_0 + {4'd0, n}) : (CH_A + {4'd0, n} - 8'd10);
  endfunction

endpackage

// File: rtl/acp_frame_rx.sv
module acp_frame_rx
  import acp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_acc_i,
  output logic              fire_o,
  output logic              is_wr_o,
  output logic [7:0]        id_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int HEX_DIGITS = DATA_W / 4;
  localparam int CNT_W      = $clog2(HEX_DIGITS);

  pstate_e            st_q;
  pstate_e            restart;
  logic [CNT_W-1:0]   cnt_q;
  logic               is_wr_q;
  logic [3:0]         id_hi_q, id_lo_q;
  logic [DATA_W-1:0]  data_q;

  // a stray '?' always begins a fresh frame
  assign restart = (rx_data_i == CH_Q) ? PS_D : PS_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PS_IDLE;
      cnt_q   <= '0;
      is_wr_q <= 1'b0;
      id_hi_q <= '0;
      id_lo_q <= '0;
      data_q  <= '0;
    end else if (rx_acc_i) begin
      unique case (st_q)
        PS_IDLE: st_q <= restart;
        PS_D:    st_q <= (rx_data_i == CH_D)   ? PS_E   : restart;
        PS_E:    st_q <= (rx_data_i == CH_E)   ? PS_V   : restart;
        PS_V:    st_q <= (rx_data_i == CH_V)   ? PS_COL : restart;
        PS_COL:  st_q <= (rx_data_i == CH_COL) ? PS_ID0 : restart;
        PS_ID0: begin
          if (is_dec(rx_data_i)) begin
            id_hi_q <= rx_data_i[3:0];
            st_q    <= PS_ID1;
          end else st_q <= restart;
        end
        PS_ID1: begin
          if (is_dec(rx_data_i)) begin
            id_lo_q <= rx_data_i[3:0];
            st_q    <= PS_DIR;
          end else st_q <= restart;
        end
        PS_DIR: begin
          if (rx_data_i == CH_COL) begin
            is_wr_q <= 1'b1;
            cnt_q   <= '0;
            st_q    <= PS_DATA;
          end else if (rx_data_i == CH_Q) begin
            is_wr_q <= 1'b0;
            st_q    <= PS_CR;
          end else st_q <= PS_IDLE;
        end
        PS_DATA: begin
          if (is_hex(rx_data_i)) begin
            data_q <= {data_q[DATA_W-5:0], hex_val(rx_data_i)};
            if (cnt_q == CNT_W'(HEX_DIGITS - 1)) st_q <= PS_CR;
            else cnt_q <= cnt_q + 1'b1;
          end else st_q <= restart;
        end
        PS_CR:   st_q <= (rx_data_i == CH_CR) ? PS_LF : restart;
        PS_LF:   st_q <= (rx_data_i == CH_LF) ? PS_IDLE : restart;
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  assign fire_o  = rx_acc_i && (st_q == PS_LF) && (rx_data_i == CH_LF);
  assign is_wr_o = is_wr_q;
  assign id_o    = {id_hi_q, id_lo_q};
  assign data_o  = data_q;

  AST_FIRE_RETURNS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> st_q == PS_IDLE); // R1
  AST_DATA_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == PS_DATA |-> is_wr_q); // R8

endmodule

// File: rtl/acp_regs.sv
module acp_regs
  import acp_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          COEF_W    = 16,
  parameter int          AVG_W     = 3,
  parameter int          AVG_MAX   = 6,
  parameter int          MODE_W    = 3,
  parameter int          MODE_MIN  = 1,
  parameter int          MODE_MAX  = 6,
  parameter int          SEL_W     = 5,
  parameter logic [31:0] OFFS_LO   = 32'hFFA07413,
  parameter logic [31:0] OFFS_HI   = 32'h005F8BED,
  parameter int          KI_RST    = 2,
  parameter int          KP_RST    = 200,
  parameter int          KD_RST    = 0,
  parameter int          SEL_RST   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              is_wr_i,
  input  logic [7:0]        id_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] offset_o,
  output logic              track_o,
  output logic [AVG_W-1:0]  avg_o,
  output logic [COEF_W-1:0] ki_o,
  output logic [COEF_W-1:0] kp_o,
  output logic [COEF_W-1:0] kd_o,
  output logic              clear_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic              wr_ok, rd_ok, commit;
  logic              coef_ok;
  logic [DATA_W-1:0] offset_q;
  logic              track_q, clear_q;
  logic [AVG_W-1:0]  avg_q;
  logic [COEF_W-1:0] ki_q, kp_q, kd_q;
  logic [MODE_W-1:0] mode_q;
  logic [SEL_W-1:0]  sel_q;

  assign coef_ok = (wdata_i >> COEF_W) == '0;

  always_comb begin
    wr_ok   = 1'b0;
    rd_ok   = 1'b1;
    rdata_o = '0;
    unique case (id_i)
      ID_STATUS: begin
        rdata_o = status_i;
      end
      ID_OFFS_A, ID_OFFS_B: begin
        rdata_o = offset_q;
        wr_ok   = ($signed(wdata_i) >= $signed(OFFS_LO)) && ($signed(wdata_i) <= $signed(OFFS_HI));
      end
      ID_BITSEL: begin
        rdata_o = DATA_W'(sel_q);
        wr_ok   = wdata_i < DATA_W'(1 << SEL_W);
      end
      ID_TRACK: begin
        rdata_o = DATA_W'(track_q);
        wr_ok   = wdata_i <= DATA_W'(1);
      end
      ID_AVG: begin
        rdata_o = DATA_W'(avg_q);
        wr_ok   = wdata_i <= DATA_W'(AVG_MAX);
      end
      ID_KI: begin
        rdata_o = DATA_W'(ki_q);
        wr_ok   = coef_ok;
      end
      ID_KP: begin
        rdata_o = DATA_W'(kp_q);
        wr_ok   = coef_ok;
      end
      ID_KD: begin
        rdata_o = DATA_W'(kd_q);
        wr_ok   = coef_ok;
      end
      ID_CLEAR: begin
        rd_ok = 1'b0;
        wr_ok = 1'b1;
      end
      ID_PMODE: begin
        rdata_o = DATA_W'(mode_q);
        wr_ok   = (wdata_i >= DATA_W'(MODE_MIN)) && (wdata_i <= DATA_W'(MODE_MAX));
      end
      default: rd_ok = 1'b0;
    endcase
  end

  assign commit = fire_i && is_wr_i && wr_ok;
  assign ack_o  = fire_i && (is_wr_i ? wr_ok : rd_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_q <= '0;
      track_q  <= 1'b1;
      avg_q    <= '0;
      ki_q     <= COEF_W'(KI_RST);
      kp_q     <= COEF_W'(KP_RST);
      kd_q     <= COEF_W'(KD_RST);
      mode_q   <= MODE_W'(MODE_MIN);
      sel_q    <= SEL_W'(SEL_RST);
      clear_q  <= 1'b0;
    end else begin
      clear_q <= commit && (id_i == ID_CLEAR);
      if (commit) begin
        unique case (id_i)
          ID_OFFS_A, ID_OFFS_B: offset_q <= wdata_i;
          ID_BITSEL:            sel_q    <= wdata_i[SEL_W-1:0];
          ID_TRACK:             track_q  <= wdata_i[0];
          ID_AVG:               avg_q    <= wdata_i[AVG_W-1:0];
          ID_KI:                ki_q     <= wdata_i[COEF_W-1:0];
          ID_KP:                kp_q     <= wdata_i[COEF_W-1:0];
          ID_KD:                kd_q     <= wdata_i[COEF_W-1:0];
          ID_PMODE:             mode_q   <= wdata_i[MODE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign offset_o = offset_q;
  assign track_o  = track_q;
  assign avg_o    = avg_q;
  assign ki_o     = ki_q;
  assign kp_o     = kp_q;
  assign kd_o     = kd_q;
  assign clear_o  = clear_q;
  assign mode_o   = mode_q;
  assign sel_o    = sel_q;

  AST_OFFS_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(offset_q) >= $signed(OFFS_LO)) && ($signed(offset_q) <= $signed(OFFS_HI))); // R3
  AST_AVG_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(avg_q) <= 32'(AVG_MAX)); // R4
  AST_MODE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(mode_q) >= 32'(MODE_MIN)) && (32'(mode_q) <= 32'(MODE_MAX))); // R7
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_q |=> !clear_q); // R6

endmodule

// File: rtl/acp_resp_tx.sv
module acp_resp_tx
  import acp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_rd_i,
  input  logic [7:0]        id_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              tx_ready_i,
  output logic              busy_o,
  output logic [7:0]        tx_data_o
);
  localparam int HEX_DIGITS = DATA_W / 4;
  localparam int OK_LEN     = 9;
  localparam int RD_LEN     = 10 + HEX_DIGITS;
  localparam int IDX_W      = $clog2(RD_LEN);

  logic              busy_q, is_rd_q;
  logic [IDX_W-1:0]  idx_q, last_idx;
  logic [7:0]        id_q;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_sh;
  int unsigned       dig;

  assign last_idx = is_rd_q ? IDX_W'(RD_LEN - 1) : IDX_W'(OK_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
      idx_q   <= '0;
      id_q    <= '0;
      word_q  <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      is_rd_q <= is_rd_i;
      idx_q   <= '0;
      id_q    <= id_i;
      word_q  <= word_i;
    end else if (busy_q && tx_ready_i) begin
      if (idx_q == last_idx) busy_q <= 1'b0;
      else idx_q <= idx_q + 1'b1;
    end
  end

  // digit position counted from the least significant nibble
  always_comb begin
    dig     = 32'(HEX_DIGITS + 7) - 32'(idx_q);
    word_sh = word_q >> (4 * dig);
  end

  always_comb begin
    tx_data_o = CH_LF;
    if (idx_q == IDX_W'(0))      tx_data_o = CH_Q;
    else if (idx_q == IDX_W'(1)) tx_data_o = CH_D;
    else if (idx_q == IDX_W'(2)) tx_data_o = CH_E;
    else if (idx_q == IDX_W'(3)) tx_data_o = CH_V;
    else if (idx_q == IDX_W'(4)) tx_data_o = CH_COL;
    else if (!is_rd_q) begin
      if (idx_q == IDX_W'(5))      tx_data_o = CH_O;
      else if (idx_q == IDX_W'(6)) tx_data_o = CH_K;
      else if (idx_q == IDX_W'(7)) tx_data_o = CH_CR;
    end else begin
      if (idx_q == IDX_W'(5))                     tx_data_o = nib_char(id_q[7:4]);
      else if (idx_q == IDX_W'(6))                tx_data_o = nib_char(id_q[3:0]);
      else if (idx_q == IDX_W'(7))                tx_data_o = CH_COL;
      else if (idx_q < IDX_W'(8 + HEX_DIGITS))    tx_data_o = nib_char(word_sh[3:0]);
      else if (idx_q == IDX_W'(8 + HEX_DIGITS))   tx_data_o = CH_CR;
    end
  end

  assign busy_o = busy_q;

  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R10
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tx_ready_i |=> busy_q && $stable(tx_data_o)); // R10
  AST_TX_FIRST_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> tx_data_o == CH_Q); // R1

endmodule

// File: rtl/ascii_cmd_parser.sv
module ascii_cmd_parser
  import acp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int COEF_W = 16,
  parameter int AVG_W  = 3,
  parameter int MODE_W = 3,
  parameter int SEL_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] freq_offset_o,
  output logic              track_en_o,
  output logic [AVG_W-1:0]  avg_code_o,
  output logic [COEF_W-1:0] pid_ki_o,
  output logic [COEF_W-1:0] pid_kp_o,
  output logic [COEF_W-1:0] pid_kd_o,
  output logic              corr_clear_o,
  output logic [MODE_W-1:0] pin_mode_o,
  output logic [SEL_W-1:0]  status_sel_o
);
  logic              rx_acc, fire, is_wr, ack, busy;
  logic [7:0]        id;
  logic [DATA_W-1:0] wdata, rdata;

  assign rx_ready_o = !busy;
  assign rx_acc     = rx_valid_i && !busy;
  assign tx_valid_o = busy;

  acp_frame_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .rx_data_i, .rx_acc_i(rx_acc),
    .fire_o(fire), .is_wr_o(is_wr), .id_o(id), .data_o(wdata)
  );

  acp_regs #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .AVG_W(AVG_W), .MODE_W(MODE_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .fire_i(fire), .is_wr_i(is_wr), .id_i(id), .wdata_i(wdata), .status_i,
    .ack_o(ack), .rdata_o(rdata),
    .offset_o(freq_offset_o), .track_o(track_en_o), .avg_o(avg_code_o),
    .ki_o(pid_ki_o), .kp_o(pid_kp_o), .kd_o(pid_kd_o),
    .clear_o(corr_clear_o), .mode_o(pin_mode_o), .sel_o(status_sel_o)
  );

  acp_resp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni,
    .start_i(ack), .is_rd_i(!is_wr), .id_i(id), .word_i(rdata),
    .tx_ready_i, .busy_o(busy), .tx_data_o
  );

endmodule

// File: tb/sim_ascii_cmd_parser.sv
module sim_ascii_cmd_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic        bp = 1'b0;
  logic [31:0] status = 32'h1234ABCD;
  logic [31:0] offs;
  logic        track, clr;
  logic [2:0]  avg, mode;
  logic [15:0] ki, kp, kd;
  logic [4:0]  sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] cap[$];

  always #10 clk = ~clk;

  ascii_cmd_parser u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .status_i(status),
    .freq_offset_o(offs), .track_en_o(track), .avg_code_o(avg),
    .pid_ki_o(ki), .pid_kp_o(kp), .pid_kd_o(kd),
    .corr_clear_o(clr), .pin_mode_o(mode), .status_sel_o(sel)
  );

  always @(posedge clk) if (tx_valid && tx_ready) cap.push_back(tx_data);
  always @(negedge clk) tx_ready <= bp ? ~tx_ready : 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_raw(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic send_line(input string s);
    send_raw(s);
    send_byte(8'h0D);
    send_byte(8'h0A);
  endtask

  // body excludes CR LF; empty body means no reply expected
  task automatic expect_rsp(input string body, input string req);
    string got;
    bit    ok;
    repeat (60) @(negedge clk);
    got = "";
    for (int i = 0; i < cap.size(); i++) got = $sformatf("%s%c", got, cap[i]);
    if (body.len() == 0) begin
      ok = (cap.size() == 0);
    end else begin
      ok = (cap.size() == body.len() + 2);
      if (ok) begin
        for (int i = 0; i < body.len(); i++) if (cap[i] != body[i]) ok = 0;
        if (cap[body.len()] != 8'h0D || cap[body.len()+1] != 8'h0A) ok = 0;
      end
    end
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s reply: actual \"%s\" (%0d bytes) expected \"%s\"+CRLF",
               req, got, cap.size(), body);
    end
    cap.delete();
  endtask

  task automatic t_reset();
    chk(offs == 0, "R11", "offset", offs, 0);
    chk(track == 1, "R11", "track", 32'(track), 1);
    chk(avg == 0, "R11", "avg", 32'(avg), 0);
    chk(ki == 2 && kp == 200 && kd == 0, "R11", "ki/kp/kd", {ki, kp}, {16'd2, 16'd200});
    chk(mode == 1 && sel == 16, "R11", "mode/sel", {mode, sel}, {3'd1, 5'd16});
    chk(!tx_valid && rx_ready, "R11", "handshake", {tx_valid, rx_ready}, 2'b01);
  endtask

  task automatic t_status();
    send_line("?DEV:03?");
    expect_rsp("?DEV:03:1234ABCD", "R2");
  endtask

  task automatic t_offset();
    send_line("?DEV:13:005F8BED");
    chk(offs == 32'h005F8BED, "R3", "offset max", offs, 32'h005F8BED);
    expect_rsp("?DEV:OK", "R1");
    send_line("?DEV:14:FFA07413");
    chk(offs == 32'hFFA07413, "R3", "offset min", offs, 32'hFFA07413);
    expect_rsp("?DEV:OK", "R3");
    send_line("?DEV:13:005F8BEE");
    expect_rsp("", "R3");
    send_line("?DEV:14:FFA07412");
    expect_rsp("", "R3");
    chk(offs == 32'hFFA07413, "R3", "offset kept", offs, 32'hFFA07413);
    send_line("?DEV:13?");
    expect_rsp("?DEV:13:FFA07413", "R3");
  endtask

  task automatic t_small();
    send_line("?DEV:81:00000000");
    expect_rsp("?DEV:OK", "R4");
    chk(track == 0, "R4", "track", 32'(track), 0);
    send_line("?DEV:81:00000002");
    expect_rsp("", "R4");
    send_line("?DEV:82:00000006");
    expect_rsp("?DEV:OK", "R4");
    send_line("?DEV:82:00000007");
    expect_rsp("", "R4");
    chk(avg == 6, "R4", "avg", 32'(avg), 6);
    send_line("?DEV:19:0000001F");
    expect_rsp("?DEV:OK", "R4");
    send_line("?DEV:19:00000020");
    expect_rsp("", "R4");
    chk(sel == 31, "R4", "sel", 32'(sel), 31);
    send_line("?DEV:82?");
    expect_rsp("?DEV:82:00000006", "R4");
  endtask

  task automatic t_coef();
    send_line("?DEV:84:0000FFFF");
    expect_rsp("?DEV:OK", "R5");
    send_line("?DEV:83:00010000");
    expect_rsp("", "R5");
    send_line("?DEV:85:0000A5C3");
    expect_rsp("?DEV:OK", "R5");
    chk(kp == 16'hFFFF && ki == 2 && kd == 16'hA5C3, "R5", "kp/ki/kd",
        {kp, ki}, {16'hFFFF, 16'd2});
    send_line("?DEV:84?");
    expect_rsp("?DEV:84:0000FFFF", "R5");
  endtask

  task automatic t_clear();
    send_line("?DEV:86:DEADBEEF");
    chk(clr == 1, "R6", "clear high", 32'(clr), 1);
    @(negedge clk);
    chk(clr == 0, "R6", "clear low", 32'(clr), 0);
    expect_rsp("?DEV:OK", "R6");
  endtask

  task automatic t_mode();
    send_line("?DEV:88:00000000");
    expect_rsp("", "R7");
    send_line("?DEV:88:00000006");
    expect_rsp("?DEV:OK", "R7");
    send_line("?DEV:88:00000007");
    expect_rsp("", "R7");
    chk(mode == 6, "R7", "mode", 32'(mode), 6);
  endtask

  task automatic t_malformed();
    send_line("?DEV:13:0000abcd");
    expect_rsp("", "R8");
    chk(offs == 32'hFFA07413, "R8", "offset kept", offs, 32'hFFA07413);
    send_line("?DEV:8A:00000001");
    expect_rsp("", "R8");
    send_raw("xy?DEV:8");
    send_line("?DEV:81?");
    expect_rsp("?DEV:81:00000000", "R8");
  endtask

  task automatic t_unknown();
    send_line("?DEV:55:00000001");
    expect_rsp("", "R9");
    send_line("?DEV:03:00000000");
    expect_rsp("", "R9");
    send_line("?DEV:86?");
    expect_rsp("", "R9");
    chk(track == 0 && avg == 6 && mode == 6, "R9", "regs unchanged",
        {track, avg, mode}, {1'b0, 3'd6, 3'd6});
  endtask

  task automatic t_backpressure();
    bp = 1'b1;
    send_line("?DEV:19?");
    chk(tx_valid && !rx_ready, "R10", "busy handshake", {tx_valid, rx_ready}, 2'b10);
    expect_rsp("?DEV:19:0000001F", "R10");
    bp = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_offset();
    t_small();
    t_coef();
    t_clear();
    t_mode();
    t_malformed();
    t_unknown();
    t_backpressure();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule